// File: doc/BRIEF.md
# Event Buffer Interrupt Register

This block tracks which buffers of a readout memory hold a validated event. Each buffer owns one valid bit. Accepted events arrive on a valid/ready stream, and each one is placed into the next buffer in a fixed rotation. Accepting an event sets that buffer's bit, stores an info word holding a running trigger number and the event's readout type, and raises the processor interrupt when a bit selected by the mask register is set. The processor reads the valid bits through a small register port. It frees a buffer by writing a 1 to that buffer's bit position.

Hardware may run several events ahead of software. When the next buffer in the rotation still holds unread data, the block stops accepting events. It drops `evt_ready` and raises `busy_o` until software frees that buffer. The stream follows the usual back-pressure rule: an event is taken only on a rising clock edge where `evt_valid` and `evt_ready` are both high. A producer that sees `evt_ready` low must keep `evt_valid` and `evt_type` steady until the event is taken. A register write and an event may land in the same cycle, and neither is lost.

An event whose readout type marks the end of a run also sets a sticky flag in the control register. Software clears that flag by writing 1 to it.

Top module: `ebi_intr_reg`

## Requirements
- R1: Valid bits (register address 0, bit b for buffer b) become set only through an accepted event. A write to address 0 never sets a bit, even where it writes 1 to a bit that is clear.
- R2: When an event sets one bit and a write to address 0 clears a different bit in the same cycle, both changes take effect. When both target the same bit, the set wins and the bit stays set.
- R3: A write to address 0 clears exactly the bits written as 1. Every other bit keeps its value, and a write of all zeros changes nothing.
- R4: A set valid bit reads back as set on every later read until software clears it.
- R5: `irq_o` is high whenever some valid bit is set whose mask bit is also set. The mask sits at address 1, bit b for buffer b, and can be read and written.
- R6: Accepted events fill buffers in strict order 0, 1, …, NBUF-1, then wrap to 0. Each accepted event sets exactly one bit.
- R7: `busy_o` is high and `evt_ready` is low while the next buffer in the rotation is still valid, and an event offered then is not taken. When all buffers are full and software clears that buffer's bit, `busy_o` falls in the cycle after the write.
- R8: To read a buffer's info word, write the buffer number to address 3, then read address 3. The word is laid out as follows:
  - bits [TRIG_W-1:0] hold the trigger number, which is 0 for the first event after reset and rises by one per accepted event;
  - bits [TRIG_W+1:TRIG_W] hold the readout type of that event.
- R9: An accepted event of readout type 3 (end of run) sets bit 0 of address 2. Writing 1 to that bit clears it.
- R10: After reset, all valid bits, the mask, the end-of-run flag and the trigger counter are zero, `busy_o` and `irq_o` are low, and allocation starts at buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An event is offered |
| evt_ready | output | 1 | The next buffer is free, so the event can be taken |
| evt_type | input | 2 | Readout type of the offered event (3 = end of run) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 valid bits, 1 mask, 2 control, 3 info |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Interrupt to the processor's event pin |
| busy_o | output | 1 | Buffers-full busy |

## Verification
The checker assumes that `evt_valid` is low while reset is held. It also assumes that the stream and the register inputs change only away from the rising edge, so the set and clear vectors it compares belong to one cycle. The bench drives every input on the falling edge and keeps the stream idle through reset. It deliberately creates the hard cases for the arbitration: a clear and a set in the same cycle on different bits and on the same bit, clears aimed at bits that are not set, and events offered while busy.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
  // readout types carried with each event
  typedef enum logic [1:0] {
    RT_PHYS = 2'd0,
    RT_TEST = 2'd1,
    RT_CAL  = 2'd2,
    RT_EOR  = 2'd3
  } rtype_e;

  // register addresses
  localparam logic [1:0] A_VALID = 2'd0;
  localparam logic [1:0] A_MASK  = 2'd1;
  localparam logic [1:0] A_CTRL  = 2'd2;
  localparam logic [1:0] A_INFO  = 2'd3;
endpackage

// File: rtl/ebi_alloc.sv
// Round-robin buffer allocator and trigger-number counter.
module ebi_alloc #(
  parameter int NBUF   = 9,
  parameter int TRIG_W = 16,
  localparam int PW    = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  output logic [PW-1:0]     ptr,
  output logic [TRIG_W-1:0] trig_num,
  output logic [NBUF-1:0]   set_vec
);
  localparam logic [PW-1:0] LAST = PW'(NBUF - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      trig_num <= '0;
    end else if (accept) begin
      ptr      <= (ptr == LAST) ? '0 : ptr + 1'b1;
      trig_num <= trig_num + 1'b1;
    end
  end

  // one-hot set request for the buffer being filled (R6)
  for (genvar b = 0; b < NBUF; b++) begin : g_set
    assign set_vec[b] = accept && (ptr == PW'(b));
  end
endmodule

// File: rtl/ebi_valid_bits.sv
// Valid-bit register: hardware sets, software clears, set wins on collision.
module ebi_valid_bits #(
  parameter int NBUF = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] set_vec,
  input  logic [NBUF-1:0] clr_vec,
  output logic [NBUF-1:0] valid_q
);
  for (genvar b = 0; b < NBUF; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          valid_q[b] <= 1'b0;
      else if (set_vec[b]) valid_q[b] <= 1'b1;   // R2: set wins
      else if (clr_vec[b]) valid_q[b] <= 1'b0;   // R3: only selected bit
    end
  end
endmodule

// File: rtl/ebi_info_store.sv
// Per-buffer info words: {readout type, trigger number}.
module ebi_info_store #(
  parameter int NBUF   = 9,
  parameter int TRIG_W = 16,
  localparam int PW    = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int IW    = TRIG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBUF-1:0]   we_vec,
  input  logic [1:0]        wr_type,
  input  logic [TRIG_W-1:0] wr_trig,
  input  logic [PW-1:0]     rd_sel,
  output logic [IW-1:0]     rd_word
);
  logic [IW-1:0] words [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         words[b] <= '0;
      else if (we_vec[b]) words[b] <= {wr_type, wr_trig};
    end
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NBUF; b++) begin
      if (rd_sel == PW'(b)) rd_word = words[b];
    end
  end
endmodule

// File: rtl/ebi_intr_reg.sv
// Event buffer interrupt register: top level.
module ebi_intr_reg
  import ebi_pkg::*;
#(
  parameter int NBUF   = 9,
  parameter int TRIG_W = 16,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic [1:0]    evt_type,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o,
  output logic          busy_o
);
  localparam int PW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int IW = TRIG_W + 2;

  logic              accept;
  logic [PW-1:0]     ptr;
  logic [TRIG_W-1:0] trig_num;
  logic [NBUF-1:0]   set_vec;
  logic [NBUF-1:0]   clr_vec;
  logic [NBUF-1:0]   valid_q;
  logic [NBUF-1:0]   mask_q;
  logic              eor_q;
  logic [PW-1:0]     info_sel_q;
  logic [IW-1:0]     info_word;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DW-1:NBUF];

  // R7: the next buffer in rotation must be free
  assign busy_o    = valid_q[ptr];
  assign evt_ready = !busy_o;
  assign accept    = evt_valid && evt_ready;

  // R1/R3: write-1-to-clear, never sets
  assign clr_vec = (reg_we && reg_addr == A_VALID) ? reg_wdata[NBUF-1:0] : '0;

  ebi_alloc #(.NBUF(NBUF), .TRIG_W(TRIG_W)) alloc_i (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .ptr(ptr), .trig_num(trig_num), .set_vec(set_vec)
  );

  ebi_valid_bits #(.NBUF(NBUF)) bits_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_vec(clr_vec), .valid_q(valid_q)
  );

  ebi_info_store #(.NBUF(NBUF), .TRIG_W(TRIG_W)) info_i (
    .clk(clk), .rst_n(rst_n), .we_vec(set_vec), .wr_type(evt_type),
    .wr_trig(trig_num), .rd_sel(info_sel_q), .rd_word(info_word)
  );

  // mask, end-of-run flag, info selector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      eor_q      <= 1'b0;
      info_sel_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_MASK) mask_q <= reg_wdata[NBUF-1:0];
      if (reg_we && reg_addr == A_INFO) info_sel_q <= reg_wdata[PW-1:0];
      if (accept && evt_type == RT_EOR)             eor_q <= 1'b1;  // R9
      else if (reg_we && reg_addr == A_CTRL && reg_wdata[0]) eor_q <= 1'b0;
    end
  end

  assign irq_o = |(valid_q & mask_q);  // R5

  always_comb begin
    unique case (reg_addr)
      A_VALID: reg_rdata = DW'(valid_q);
      A_MASK:  reg_rdata = DW'(mask_q);
      A_CTRL:  reg_rdata = DW'(eor_q);
      default: reg_rdata = DW'(info_word);
    endcase
  end
endmodule

// File: rtl/ebi_intr_reg_chk.sv
module ebi_intr_reg_chk #(
  parameter int NBUF = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NBUF-1:0] valid_q,
  input logic [NBUF-1:0] set_vec,
  input logic [NBUF-1:0] clr_vec,
  input logic            busy_o
);
  // R1: a bit only rises where hardware requested it
  p_hw_only_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((valid_q & ~$past(valid_q) & ~$past(set_vec)) == '0));

  // R2: every set lands, and a clear of a different bit lands too
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~valid_q) == '0));
  p_clear_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_vec) & ~$past(set_vec) & valid_q) == '0));

  // R3 / R4: bits not cleared keep their value
  p_others_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(valid_q) & ~$past(clr_vec) & ~valid_q) == '0));

  // R6: at most one buffer allocated per cycle
  p_single_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));

  // R7: nothing is allocated while busy
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (set_vec == '0));
endmodule

bind ebi_intr_reg ebi_intr_reg_chk #(.NBUF(NBUF)) chk_i (
  .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .set_vec(set_vec),
  .clr_vec(clr_vec), .busy_o(busy_o)
);

// File: tb/ebi_intr_reg_tb_top.sv
module ebi_intr_reg_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evt_valid = 1'b0;
  logic          evt_ready;
  logic [1:0]    evt_type = 2'd0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_o, busy_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ebi_intr_reg #(.NBUF(9), .TRIG_W(16), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_type(evt_type), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .busy_o(busy_o)
  );

  // vector: [43:40] req, [39] ev, [38:37] type, [36] we, [35:34] addr,
  //         [33:18] wdata, [17:2] expected valid bits, [1] busy, [0] irq
  localparam int NV = 17;
  localparam logic [43:0] VEC [NV] = '{
    {4'd5, 1'b0, 2'd0, 1'b1, 2'd1, 16'h0001, 16'h0000, 1'b0, 1'b0}, // R5 mask
    {4'd6, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h0001, 1'b0, 1'b1}, // R6
    {4'd6, 1'b1, 2'd1, 1'b0, 2'd0, 16'h0000, 16'h0003, 1'b0, 1'b1}, // R6
    {4'd2, 1'b1, 2'd0, 1'b1, 2'd0, 16'h0001, 16'h0006, 1'b0, 1'b0}, // R2 contention
    {4'd3, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0000, 16'h0006, 1'b0, 1'b0}, // R3 zero write
    {4'd1, 1'b0, 2'd0, 1'b1, 2'd0, 16'h01F8, 16'h0006, 1'b0, 1'b0}, // R1 no sw set
    {4'd6, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h000E, 1'b0, 1'b0},
    {4'd6, 1'b1, 2'd2, 1'b0, 2'd0, 16'h0000, 16'h001E, 1'b0, 1'b0},
    {4'd6, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h003E, 1'b0, 1'b0},
    {4'd6, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h007E, 1'b0, 1'b0},
    {4'd6, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h00FE, 1'b0, 1'b0},
    {4'd6, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h01FE, 1'b0, 1'b0},
    {4'd7, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h01FF, 1'b1, 1'b1}, // R7 full
    {4'd7, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0000, 16'h01FF, 1'b1, 1'b1}, // R7 refused
    {4'd7, 1'b0, 2'd0, 1'b1, 2'd0, 16'h0002, 16'h01FD, 1'b0, 1'b1}, // R7 release
    {4'd2, 1'b1, 2'd0, 1'b1, 2'd0, 16'h0002, 16'h01FF, 1'b1, 1'b1}, // R2 same bit
    {4'd3, 1'b0, 2'd0, 1'b1, 2'd0, 16'h01FF, 16'h0000, 1'b0, 1'b0}  // R3 clear all
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ev, input logic [1:0] ty, input logic we,
                     input logic [1:0] ad, input logic [DW-1:0] wd);
    @(negedge clk);
    evt_valid = ev; evt_type = ty; reg_we = we; reg_addr = ad; reg_wdata = wd;
    @(posedge clk);
    #2;
    evt_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] ad, output logic [DW-1:0] d);
    reg_addr = ad;
    #1;
    d = reg_rdata;
  endtask

  logic [DW-1:0] d;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R10: reset state
    rd(2'd0, d); chk("R10 valid", d, 0);
    rd(2'd1, d); chk("R10 mask", d, 0);
    rd(2'd2, d); chk("R10 ctrl", d, 0);
    chk("R10 busy", {31'd0, busy_o}, 0);
    chk("R10 irq", {31'd0, irq_o}, 0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][39], VEC[i][38:37], VEC[i][36], VEC[i][35:34], DW'(VEC[i][33:18]));
      rd(2'd0, d);
      chk($sformatf("R%0d valid v%0d", VEC[i][43:40], i), d, DW'(VEC[i][17:2]));
      chk($sformatf("R%0d busy v%0d", VEC[i][43:40], i), {31'd0, busy_o}, {31'd0, VEC[i][1]});
      chk($sformatf("R%0d irq v%0d", VEC[i][43:40], i), {31'd0, irq_o}, {31'd0, VEC[i][0]});
      chk($sformatf("R7 ready v%0d", i), {31'd0, evt_ready}, {31'd0, ~VEC[i][1]});
    end

    // R5: mask reads back
    rd(2'd1, d); chk("R5 mask readback", d, 32'h1);
    // R8: info words; events 0..10 accepted, buffer 1 last got trig 10
    cyc(1'b0, 2'd0, 1'b1, 2'd3, 32'd1); rd(2'd3, d); chk("R8 buf1", d, 32'h0000A);
    cyc(1'b0, 2'd0, 1'b1, 2'd3, 32'd0); rd(2'd3, d); chk("R8 buf0", d, 32'h00009);
    cyc(1'b0, 2'd0, 1'b1, 2'd3, 32'd4); rd(2'd3, d); chk("R8 buf4 type2", d, 32'h20004);
    // R9: end-of-run event lands in buffer 2 with trig 11
    cyc(1'b1, 2'd3, 1'b0, 2'd0, 32'd0);
    rd(2'd2, d); chk("R9 eor set", d, 32'h1);
    rd(2'd0, d); chk("R6 buf2 next", d, 32'h4);
    cyc(1'b0, 2'd0, 1'b1, 2'd3, 32'd2); rd(2'd3, d); chk("R8 R9 eor info", d, 32'h3000B);
    // R4: bit holds over idle cycles
    repeat (5) @(posedge clk);
    #2 rd(2'd0, d); chk("R4 hold", d, 32'h4);
    cyc(1'b0, 2'd0, 1'b1, 2'd2, 32'h1);
    rd(2'd2, d); chk("R9 eor cleared", d, 32'h0);
    rd(2'd0, d); chk("R3 ctrl write leaves valid", d, 32'h4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule